// File: doc/BRIEF.md
# Floating-point mode register and per-instruction mode resolver

This block keeps a 32-bit floating-point control/status word and, for each floating-point instruction presented to it, works out which rounding mode and which accuracy mode apply. It also decides whether the instruction must raise an illegal-instruction trap. The word holds sticky exception flags, a dynamic rounding mode and a 2-bit accuracy mode. The accuracy mode occupies bits that older layouts left unused. Mode 0 means full IEEE 754 accuracy, so software that never touches the field sees standard behaviour.

An instruction names a rounding mode in its own 3-bit field. The all-ones value defers to the stored dynamic mode. Each instruction also carries an operation-class code. Whether a given pair of accuracy mode and operation class runs in hardware comes from a parameter table. A pair the table does not list traps, so that software can emulate it. The resolution is combinational against the stored word. CSR writes and flag accumulation land on the next rising clock edge.

Top module: `fp_mode_ctl`

## Requirements
- R1: After reset the whole word reads zero. Flags sit in bits [4:0], the dynamic rounding mode in bits [7:5], and the accuracy mode in bits [9:8].
- R2: When the instruction rounding field is 000 to 100, `res_rm` equals that field.
- R3: When the instruction rounding field is 111, `res_rm` equals the stored dynamic rounding mode.
- R4: A valid instruction with rounding field 111 traps if the stored dynamic mode is 101, 110 or 111.
- R5: A valid instruction with rounding field 101 or 110 traps, whatever the stored dynamic mode is.
- R6: Accuracy mode 00 never causes a trap for any operation class, even if the table bit for it is clear.
- R7: For a nonzero accuracy mode, a valid instruction traps unless bit `{acc, cls}` of `SUPPORT_MAP` is set. The default map supports mode 01 for classes 0 and 1, mode 10 for class 0 only, and mode 11 for no class.
- R8: A CSR write changes the rounding and accuracy fields at the next clock edge. `res_acc` always shows the stored accuracy mode. An instruction in the write cycle still resolves against the old values.
- R9: Each cycle, `flags_in` is ORed into the flag bits. A CSR write in the same cycle sets the flags to the written value instead.
- R10: Bits [31:10] ignore writes and always read zero.
- R11: `res_illegal` is low whenever `issue_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current control word |
| flags_in | input | 5 | Exception flags from completed operations |
| issue_vld | input | 1 | Instruction present |
| issue_rm | input | 3 | Instruction rounding field |
| issue_cls | input | CLS_W | Operation class |
| res_rm | output | 3 | Resolved rounding mode |
| res_acc | output | 2 | Resolved accuracy mode |
| res_illegal | output | 1 | Illegal-instruction trap |

## Verification
The bench aims at several corner cases, each with a known failure symptom:
- A CSR write and an instruction in the same cycle. A design that forwards the new word would resolve against the wrong mode.
- A flag write colliding with incoming flags. Letting the OR win would leave stray flags set.
- Accuracy mode 00 on classes whose table bit is clear. A design that reads the table blindly would trap there.
- Reserved rounding encodings 101 and 110 issued while the stored mode is legal. A design that only checks the dynamic path would miss these traps.
- Writes of all ones. These show whether reserved bits leak into the read value.

// File: rtl/fp_mode_ctl.sv
module fp_mode_ctl #(
  parameter int CLS_W = 2,
  parameter logic [(4<<CLS_W)-1:0] SUPPORT_MAP = 16'h0130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic [4:0]       flags_in,
  input  logic             issue_vld,
  input  logic [2:0]       issue_rm,
  input  logic [CLS_W-1:0] issue_cls,
  output logic [2:0]       res_rm,
  output logic [1:0]       res_acc,
  output logic             res_illegal
);

  logic [4:0] flags_q;
  logic [2:0] rm_q;
  logic [1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rm_q    <= '0;
      acc_q   <= '0;
    end else if (csr_we) begin
      flags_q <= csr_wdata[4:0];
      rm_q    <= csr_wdata[7:5];
      acc_q   <= csr_wdata[9:8];
    end else begin
      flags_q <= flags_q | flags_in;
    end
  end

  assign csr_rdata = {22'd0, acc_q, rm_q, flags_q};

  logic dyn_sel, rm_bad, acc_ok;
  assign dyn_sel = (issue_rm == 3'b111);
  assign rm_bad  = (issue_rm == 3'b101) || (issue_rm == 3'b110) || (dyn_sel && rm_q > 3'd4);
  assign acc_ok  = (acc_q == 2'b00) || SUPPORT_MAP[{acc_q, issue_cls}];

  assign res_rm      = dyn_sel ? rm_q : issue_rm;
  assign res_acc     = acc_q;
  assign res_illegal = issue_vld && (rm_bad || !acc_ok);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:10] == 22'd0); // R10

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> csr_rdata[9:0] == $past(csr_wdata[9:0])); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> (csr_rdata[4:0] & $past(csr_rdata[4:0])) == $past(csr_rdata[4:0])); // R9

  AST_RSV_RM_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (issue_rm == 3'b101 || issue_rm == 3'b110)) |-> res_illegal); // R5

  AST_MODE0_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && res_acc == 2'b00 && issue_rm <= 3'd4) |-> !res_illegal); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |-> !res_illegal); // R11

endmodule

// File: tb/fp_mode_ctl_bench.sv
module fp_mode_ctl_bench;
  localparam int CW = 2;
  localparam logic [15:0] MAP = 16'h0130;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [4:0] flags_in = 0;
  logic issue_vld = 0;
  logic [2:0] issue_rm = 0, res_rm;
  logic [CW-1:0] issue_cls = 0;
  logic [1:0] res_acc;
  logic res_illegal;

  int total = 0, bad = 0;
  bit done = 0;
  int m_flags = 0, m_rm = 0, m_acc = 0;

  always #10 clk = ~clk;

  fp_mode_ctl #(.CLS_W(CW), .SUPPORT_MAP(MAP)) u_fp_mode_ctl (
    .clk, .rst_n, .csr_we, .csr_wdata, .csr_rdata, .flags_in,
    .issue_vld, .issue_rm, .issue_cls, .res_rm, .res_acc, .res_illegal);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit supported(int acc, int cls);
    if (acc == 0) return 1;
    return MAP[acc*4 + cls];
  endfunction

  task automatic step(input bit we, input logic [31:0] wd, input logic [4:0] fi,
                      input bit vld, input logic [2:0] rm, input logic [CW-1:0] cls);
    int e_ill;
    string t;
    @(negedge clk);
    csr_we = we; csr_wdata = wd; flags_in = fi;
    issue_vld = vld; issue_rm = rm; issue_cls = cls;
    #1;
    chk("R9 flags", int'(csr_rdata[4:0]), m_flags);
    chk("R8 rm field", int'(csr_rdata[7:5]), m_rm);
    chk("R8 acc field", int'(csr_rdata[9:8]), m_acc);
    chk("R10 reserved", int'(csr_rdata[31:10]), 0);
    chk("R8 res_acc", int'(res_acc), m_acc);
    if (rm == 3'b111) chk("R3 res_rm", int'(res_rm), m_rm);
    else if (rm <= 3'd4) chk("R2 res_rm", int'(res_rm), int'(rm));
    e_ill = 0;
    if (!vld) t = "R11";
    else if (rm == 3'b101 || rm == 3'b110) begin t = "R5"; e_ill = 1; end
    else if (rm == 3'b111 && m_rm > 4) begin t = "R4"; e_ill = 1; end
    else if (m_acc != 0) begin t = "R7"; e_ill = supported(m_acc, int'(cls)) ? 0 : 1; end
    else t = "R6";
    chk({t, " illegal"}, int'(res_illegal), e_ill);
    @(posedge clk);
    if (we) begin
      m_flags = int'(wd[4:0]); m_rm = int'(wd[7:5]); m_acc = int'(wd[9:8]);
    end else m_flags = m_flags | int'(fi);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", int'(csr_rdata), 0);
    @(negedge clk); rst_n = 1;
    // R1 defaults: mode 0, rm 0
    step(0, 0, 0, 1, 3'b111, 2'd3);
    // R5 reserved instruction encodings with legal dynamic mode
    step(0, 0, 0, 1, 3'b101, 2'd0);
    step(0, 0, 0, 1, 3'b110, 2'd1);
    // R8 write dynamic rm=110 with same-cycle issue on old value
    step(1, 32'h0000_00C0, 0, 1, 3'b111, 2'd0);
    step(0, 0, 0, 1, 3'b111, 2'd0);          // R4 trap now
    step(0, 0, 0, 1, 3'b011, 2'd0);          // R2 static ok
    // R7 accuracy mode 1
    step(1, 32'h0000_0120, 0, 1, 3'b000, 2'd2);
    for (int c = 0; c < 4; c++) step(0, 0, 0, 1, 3'b001, c[1:0]);
    step(1, 32'h0000_0220, 0, 0, 3'b000, 2'd0);
    for (int c = 0; c < 4; c++) step(0, 0, 0, 1, 3'b111, c[1:0]);
    step(1, 32'h0000_0320, 0, 0, 3'b000, 2'd0);
    step(0, 0, 0, 1, 3'b000, 2'd0);
    // R6 mode 0 on every class
    step(1, 32'h0000_0000, 0, 0, 3'b000, 2'd0);
    for (int c = 0; c < 4; c++) step(0, 0, 0, 1, 3'b100, c[1:0]);
    // R9 sticky and write priority
    step(0, 0, 5'b00101, 0, 3'b000, 2'd0);
    step(0, 0, 5'b10000, 0, 3'b000, 2'd0);
    step(1, 32'h0000_0002, 5'b11101, 0, 3'b000, 2'd0);
    step(0, 0, 0, 0, 3'b000, 2'd0);
    // R10 all-ones write
    step(1, 32'hFFFF_FFFF, 0, 1, 3'b111, 2'd1);
    step(0, 0, 0, 1, 3'b111, 2'd1);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      step(($urandom % 5) == 0, wd, (($urandom % 3) == 0) ? 5'($urandom) : 5'd0,
           1'($urandom), 3'($urandom), 2'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule